// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Interpreter Model

This block is a synthesizable, device-side stand-in for a small byte-wide parallel NOR flash. Its job is to sit on the far side of a flash host controller in simulation or on a prototype. It watches single-cycle bus writes and decodes the multi-write unlock and command sequences from specific address/data pairs. Each read is answered from one of three sources: the storage array, a pair of identification bytes, or a busy status byte.

The storage is a register array split into equal, aligned sectors. Byte programming can only clear bits: new data is ANDed into the stored byte. Chip erase and sector erase return bytes to 0xFF. Each program or erase keeps the model busy for a parameterised number of clock cycles. During that time every read returns a status byte whose bit 6 flips on every status read, so a host's toggle-polling loop can be checked cycle by cycle.

Top module: `flash_cmd_model`

## Requirements
- R1: An unlock is recognised only as a write of 0xAA at address 0x555 followed by a write of 0x55 at address 0x2AA, both compared on all address bits. Any other address or data at either step gives no unlock, and the command write that follows has no effect.
- R2: After an unlock, a write of 0x90 at 0x555 enters identification mode. In this mode, a read at address 0 returns MFR_ID, a read at address 1 returns DEV_ID, and a read at any other address returns 0x00.
- R3: A write of 0xF0 at any address, made while no program is armed, leaves identification mode and returns the decoder to idle. Reads then come from the array.
- R4: After an unlock, a write of 0xA0 at 0x555 arms a program. The next write stores the bitwise AND of its data and the stored byte at array index addr modulo DEPTH.
- R5: The chain unlock, 0x80 at 0x555, unlock, 0x10 at 0x555 sets every array byte to 0xFF.
- R6: The same chain ending in 0x30 at any address sets to 0xFF only the SECT_SIZE-byte aligned sector that holds that address (index divided by SECT_SIZE). All other bytes are kept.
- R7: A program keeps the model busy for PROG_CYCLES clock cycles and an erase for ERASE_CYCLES, counted from the accepted write edge. Exactly that many back-to-back reads issued right after the write return status, and the next read returns array data.
- R8: A read while busy returns 0x00 or 0x40. Bit 6 of each such status read is the inverse of bit 6 of the previous status read.
- R9: Writes presented while the model is busy are ignored: they neither start a sequence nor change the array.
- R10: A write that is not the expected next step of a sequence sends the decoder back to idle without any effect. A fresh sequence must then start with a new unlock.
- R11: After reset, all array bytes read 0xFF, the model is in array-read mode with the decoder idle, and rdata is 0x00.
- R12: rdata is registered. It takes the value selected by a read on the clock edge that samples rd_en, and it holds while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| rd_en | input | 1 | One-cycle bus read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Read data, valid the cycle after rd_en |

## Verification
The bench builds the model with DEPTH 256, SECT_SIZE 64, PROG_CYCLES 6 and ERASE_CYCLES 10. These values make a full array dump and a four-sector erase pattern cheap, and they keep the busy windows short enough to count every status read. The six-cycle program window is longer than a complete four-write command sequence, so a whole sequence can be issued while the model is busy and shown to be ignored. With an 11-bit address, the command addresses alias onto array bytes, which exercises the modulo indexing.

// File: rtl/flash_cmd_pkg.sv
// Shared command codes and decoder state encoding for the flash model.
// Assumes a byte-wide data bus; address constants live in the decoder.
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for first unlock byte
        ST_UNL1,   // first unlock byte seen
        ST_UNL2,   // unlocked, waiting for command byte
        ST_PROG,   // program armed, next write is data
        ST_ERA1,   // erase setup seen, waiting first unlock byte
        ST_ERA2,   // waiting second unlock byte
        ST_ERA3    // waiting chip or sector erase byte
    } dec_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERSETUP = 8'h80;
    localparam logic [7:0] OP_ERCHIP  = 8'h10;
    localparam logic [7:0] OP_ERSECT  = 8'h30;
    localparam logic [7:0] OP_EXIT    = 8'hF0;
    localparam logic [7:0] STAT_ONE   = 8'h40;
endpackage

// File: rtl/flash_cmd_decoder.sv
// Command sequence decoder: tracks unlock/command writes and issues
// one-cycle program / erase strobes. Assumes ADDR_W >= 11 so that the
// 0x555 / 0x2AA command addresses fit; writes while busy are dropped.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    output dec_state_t        state,
    output logic              id_mode,
    output logic              prog_go,
    output logic              chip_go,
    output logic              sect_go
);
    localparam logic [ADDR_W-1:0] ADDR_KEY1 = ADDR_W'(11'h555);
    localparam logic [ADDR_W-1:0] ADDR_KEY2 = ADDR_W'(11'h2AA);

    dec_state_t nxt_state;
    logic       nxt_id;
    logic       at_key1, at_key2, take;

    assign at_key1 = (addr == ADDR_KEY1);
    assign at_key2 = (addr == ADDR_KEY2);
    assign take    = wr_en && !busy;

    // Next-state and strobe decode for one accepted write.
    always_comb begin
        nxt_state = state;
        nxt_id    = id_mode;
        prog_go   = 1'b0;
        chip_go   = 1'b0;
        sect_go   = 1'b0;
        if (take) begin
            if (state == ST_PROG) begin
                prog_go   = 1'b1;
                nxt_state = ST_IDLE;
            end else if (wdata == OP_EXIT) begin
                nxt_state = ST_IDLE;
                nxt_id    = 1'b0;
            end else begin
                nxt_state = ST_IDLE;
                case (state)
                    ST_IDLE: if (at_key1 && wdata == KEY_FIRST)  nxt_state = ST_UNL1;
                    ST_UNL1: if (at_key2 && wdata == KEY_SECOND) nxt_state = ST_UNL2;
                    ST_UNL2: if (at_key1) begin
                        if (wdata == OP_IDENT)        nxt_id    = 1'b1;
                        else if (wdata == OP_PROGRAM) nxt_state = ST_PROG;
                        else if (wdata == OP_ERSETUP) nxt_state = ST_ERA1;
                    end
                    ST_ERA1: if (at_key1 && wdata == KEY_FIRST)  nxt_state = ST_ERA2;
                    ST_ERA2: if (at_key2 && wdata == KEY_SECOND) nxt_state = ST_ERA3;
                    ST_ERA3: begin
                        if (at_key1 && wdata == OP_ERCHIP) chip_go = 1'b1;
                        else if (wdata == OP_ERSECT)      sect_go = 1'b1;
                    end
                    default: nxt_state = ST_IDLE;
                endcase
            end
        end
    end

    // State and identification-mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            id_mode <= 1'b0;
        end else begin
            state   <= nxt_state;
            id_mode <= nxt_id;
        end
    end
endmodule

// File: rtl/flash_busy_timer.sv
// Busy window counter: loads the program or erase duration on a start
// strobe and counts down; busy is high while the count is nonzero.
// Assumes both durations are at least 1 and starts never overlap busy.
module flash_busy_timer #(
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy
);
    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] remain;

    assign busy = (remain != '0);

    // Load on a start strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (start_erase) remain <= CNT_W'(ERASE_CYCLES);
        else if (start_prog)  remain <= CNT_W'(PROG_CYCLES);
        else if (busy)        remain <= remain - 1'b1;
    end
endmodule

// File: rtl/flash_cell_array.sv
// Register-based storage: per-byte AND programming, chip erase and
// aligned sector erase to 0xFF, asynchronous read port.
// Assumes DEPTH and SECT_SIZE are powers of two and DEPTH > SECT_SIZE.
module flash_cell_array #(
    parameter int DEPTH     = 256,
    parameter int SECT_SIZE = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_en,
    input  logic                     erase_chip,
    input  logic                     erase_sect,
    input  logic [$clog2(DEPTH)-1:0] op_idx,
    input  logic [7:0]               prog_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [7:0]               rd_data
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFS_W = $clog2(SECT_SIZE);
    localparam int SEC_W = IDX_W - OFS_W;

    logic [7:0]       cells [DEPTH];
    logic [SEC_W-1:0] op_sect;

    assign op_sect = op_idx[IDX_W-1:OFS_W];
    assign rd_data = cells[rd_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam logic [IDX_W-1:0] MY_IDX  = IDX_W'(g);
        localparam logic [SEC_W-1:0] MY_SECT = MY_IDX[IDX_W-1:OFS_W];
        // One byte: erase wins over program; program only clears bits.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[g] <= 8'hFF;
            else if (erase_chip || (erase_sect && op_sect == MY_SECT))
                cells[g] <= 8'hFF;
            else if (prog_en && op_idx == MY_IDX)
                cells[g] <= cells[g] & prog_data;
        end
    end
endmodule

// File: rtl/flash_cmd_model.sv
// Top of the byte-wide NOR flash model: decoder, busy timer, storage and
// the registered read path (array, identification bytes or status).
// Assumes single-cycle wr_en/rd_en strobes from one bus master.
module flash_cmd_model
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W       = 11,
    parameter int         DEPTH        = 256,
    parameter int         SECT_SIZE    = 64,
    parameter int         PROG_CYCLES  = 4,
    parameter int         ERASE_CYCLES = 20,
    parameter logic [7:0] MFR_ID       = 8'h3B,
    parameter logic [7:0] DEV_ID       = 8'h7E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    dec_state_t dec_state;
    logic       id_mode, busy, prog_go, chip_go, sect_go;
    logic       stat_bit;
    logic [7:0] cell_byte, id_byte;

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .state(dec_state), .id_mode(id_mode),
        .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go)
    );

    flash_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start_prog(prog_go),
        .start_erase(chip_go || sect_go), .busy(busy)
    );

    flash_cell_array #(.DEPTH(DEPTH), .SECT_SIZE(SECT_SIZE)) u_arr (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_go), .erase_chip(chip_go),
        .erase_sect(sect_go), .op_idx(addr[IDX_W-1:0]), .prog_data(wdata),
        .rd_idx(addr[IDX_W-1:0]), .rd_data(cell_byte)
    );

    // Identification byte chosen by the full read address.
    always_comb begin
        if (addr == ADDR_W'(0))      id_byte = MFR_ID;
        else if (addr == ADDR_W'(1)) id_byte = DEV_ID;
        else                         id_byte = 8'h00;
    end

    // Registered read data; status bit flips on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            stat_bit <= 1'b0;
        end else if (rd_en) begin
            if (busy) begin
                rdata    <= stat_bit ? STAT_ONE : 8'h00;
                stat_bit <= ~stat_bit;
            end else if (id_mode) begin
                rdata <= id_byte;
            end else begin
                rdata <= cell_byte;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_model_chk.sv
// Property checker for flash_cmd_model, attached by bind below.
// Assumes it sees the top's ports plus decoder state, mode and busy.
module flash_cmd_model_chk
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              busy,
    input logic              id_mode,
    input dec_state_t        state
);
    logic stat_rd_q, seen_stat, last_b6;

    // Remember whether the previous read was a status read and its bit 6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_rd_q <= 1'b0;
            seen_stat <= 1'b0;
            last_b6   <= 1'b0;
        end else begin
            stat_rd_q <= rd_en && busy;
            if (stat_rd_q) begin
                seen_stat <= 1'b1;
                last_b6   <= rdata[6];
            end
        end
    end

    assert_status_format_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_q |-> (rdata[7] == 1'b0 && rdata[5:0] == 6'd0));

    assert_status_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_q && seen_stat) |-> (rdata[6] != last_b6));

    assert_busy_decoder_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == ST_IDLE));

    assert_unlock_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNL1 && $past(state) != ST_UNL1) |->
            $past(wr_en && addr == ADDR_W'(11'h555) && wdata == 8'hAA));

    assert_exit_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wdata == 8'hF0 && state != ST_PROG) |=>
            (!id_mode && state == ST_IDLE));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind flash_cmd_model flash_cmd_model_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .id_mode(id_mode),
    .state(dec_state)
);

// File: tb/flash_cmd_model_test.sv
// Self-checking bench: directed command corners plus seeded random
// programming, compared against a bench-side byte model.
module flash_cmd_model_test;
    localparam int         CLK_PERIOD = 10;
    localparam int         AW    = 11;
    localparam int         DEPTH = 256;
    localparam int         SECT  = 64;
    localparam int         PROGC = 6;
    localparam int         ERAC  = 10;
    localparam logic [7:0] MFR   = 8'h3B;
    localparam logic [7:0] DEV   = 8'h7E;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] ref_mem [DEPTH];
    logic       have_stat = 1'b0;
    logic       prev_b6 = 1'b0;

    flash_cmd_model #(
        .ADDR_W(AW), .DEPTH(DEPTH), .SECT_SIZE(SECT), .PROG_CYCLES(PROGC),
        .ERASE_CYCLES(ERAC), .MFR_ID(MFR), .DEV_ID(DEV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // Each bus task starts and ends at a falling edge.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic unlock;
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AA, 8'h55);
    endtask

    // Expect exactly n status reads, bit 6 alternating across all of them.
    task automatic expect_busy(input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            bus_rd(11'h000, v);
            check8("R7", v & 8'hBF, 8'h00);
            if (have_stat) check8("R8", {7'd0, v[6]}, {7'd0, ~prev_b6});
            have_stat = 1'b1;
            prev_b6   = v[6];
        end
    endtask

    task automatic do_program(input logic [AW-1:0] a, input logic [7:0] d);
        unlock();
        bus_wr(11'h555, 8'hA0);
        bus_wr(a, d);
        ref_mem[a[7:0]] = ref_mem[a[7:0]] & d;
        expect_busy(PROGC);
    endtask

    task automatic do_erase(input logic chip, input logic [AW-1:0] a);
        unlock();
        bus_wr(11'h555, 8'h80);
        unlock();
        if (chip) begin
            bus_wr(11'h555, 8'h10);
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        end else begin
            bus_wr(a, 8'h30);
            for (int i = 0; i < DEPTH; i++)
                if (i / SECT == int'(a[7:0]) / SECT) ref_mem[i] = 8'hFF;
        end
        expect_busy(ERAC);
    endtask

    task automatic check_cell(input string req, input logic [AW-1:0] a);
        logic [7:0] v;
        bus_rd(a, v);
        check8(req, v, ref_mem[a[7:0]]);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < DEPTH; i++) check_cell(req, AW'(i));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] d;
        logic [AW-1:0] a;
        void'($urandom(32'h5EED));
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        check8("R11", rdata, 8'h00);
        check_cell("R11", 11'h005);
        check_cell("R11", 11'h0C8);

        // R12: rdata holds with no read
        bus_rd(11'h010, v);
        repeat (3) @(negedge clk);
        check8("R12", rdata, v);

        // R2: identification mode
        unlock();
        bus_wr(11'h555, 8'h90);
        bus_rd(11'h000, v); check8("R2", v, MFR);
        bus_rd(11'h001, v); check8("R2", v, DEV);
        bus_rd(11'h002, v); check8("R2", v, 8'h00);
        bus_rd(11'h100, v); check8("R2", v, 8'h00);
        // R3: exit back to array reads
        bus_wr(11'h000, 8'hF0);
        check_cell("R3", 11'h000);

        // R3/R10: exit in mid-sequence, then program without unlock
        unlock();
        bus_wr(11'h123, 8'hF0);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h010, 8'h00);
        check_cell("R10", 11'h010);

        // R4: AND programming and address aliasing
        do_program(11'h020, 8'hF3);
        check_cell("R4", 11'h020);
        do_program(11'h020, 8'h3C);
        check_cell("R4", 11'h020);
        check8("R4", ref_mem[8'h20], 8'h30);
        do_program(11'h321, 8'h5A);
        check_cell("R4", 11'h021);

        // R1: wrong second unlock address
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AB, 8'h55);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h040, 8'h00);
        check_cell("R1", 11'h040);
        // R1: wrong first unlock data
        bus_wr(11'h555, 8'hAB);
        bus_wr(11'h2AA, 8'h55);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h042, 8'h00);
        check_cell("R1", 11'h042);

        // R10: unknown command byte, then orphan program command
        unlock();
        bus_wr(11'h555, 8'h77);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h041, 8'h00);
        check_cell("R10", 11'h041);
        // R10: broken erase chain leaves data and no busy window
        unlock();
        bus_wr(11'h555, 8'h80);
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AA, 8'h55);
        bus_wr(11'h555, 8'h20);
        check_cell("R10", 11'h020);

        // R9: a full program sequence during busy is ignored
        unlock();
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h060, 8'h0F);
        ref_mem[8'h60] = ref_mem[8'h60] & 8'h0F;
        unlock();
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h061, 8'h00);
        expect_busy(PROGC - 4);
        check_cell("R9", 11'h060);
        check_cell("R9", 11'h061);

        // R4: seeded random programming
        for (int k = 0; k < 24; k++) begin
            a = AW'($urandom % DEPTH);
            d = 8'($urandom);
            do_program(a, d);
            check_cell("R4", a);
        end

        // R6: sector erase of sector 1 only
        do_program(11'h045, 8'h00);
        do_program(11'h085, 8'h11);
        do_program(11'h03F, 8'h22);
        do_erase(1'b0, 11'h05A);
        check_all("R6");

        // R5: chip erase
        do_program(11'h010, 8'h00);
        do_erase(1'b1, 11'h000);
        check_all("R5");

        report();
    end
endmodule